// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 level-type interrupt sources and turns them into two request lines for a processor: a fast line and a normal line. Every source carries an enable bit, a routing bit that sends it to the fast line instead of the normal one, and a 4-bit priority. The normal line is held back by a programmable 5-bit threshold, so that only sources ranked above it can raise a normal request.

Software reaches the controller through a simple 32-bit register bus with a word address, a write strobe, a read strobe, write data and registered read data. Two vector registers return the winning source when read and acknowledge it at the same time by clearing its pending bit. The normal vector picks the highest priority, and among equals the higher-numbered source. The fast vector picks the lowest-numbered source. Per-source pending, enable and routing state can be read as raw or masked views, and pending bits can also be forced from the bus.

Top module: `prio_vic`

## Requirements
- R1: A rising source input sets that source's pending bit and a falling input clears it. Raw pending reads back at word 18 (bits 63:32) and word 19 (bits 31:0). Writes to word 20 (bits 63:32) and word 21 (bits 31:0) load pending bits directly.
- R2: `fast_req_o` is high exactly when some source is pending, enabled and fast-routed (routing bit 1).
- R3: `norm_req_o` looks only at sources that are pending, enabled and normal-routed (routing bit 0). When none exist, or the threshold equals 0x1F, it is the OR of those sources. Otherwise it is high only if one of them has a priority strictly greater than the threshold.
- R4: Priorities are 4 bits, eight per 32-bit word, with source n at bits 4*(n mod 8)+3 down to 4*(n mod 8). Word 15 holds sources 0 to 7, word 14 sources 8 to 15, and so on down to word 8, which holds sources 56 to 63. All priority words are read/write.
- R5: Reading word 16 returns (index << 16) | priority for the eligible normal source with the highest priority, where the higher index wins a tie. It clears that source's pending bit. With no eligible source it returns 0xFFFFFFFF.
- R6: Reading word 17 returns the index of the lowest-numbered pending, enabled, fast-routed source and clears its pending bit. With no such source it returns 0xFFFFFFFF.
- R7: Writing word 2 sets the enable bit numbered by write-data bits 5:0, and writing word 3 clears it. Both words read as zero.
- R8: Enables are read/write at word 4 (bits 63:32) and word 5 (bits 31:0), and routing bits at word 6 (high) and word 7 (low). Pending AND enabled AND normal-routed reads at words 22/23, and pending AND enabled AND fast-routed at words 24/25, high half first. Writes to words 16 to 19 and 22 to 25 change nothing.
- R9: The threshold at word 1 keeps write-data bits 4:0 and resets to 0x1F. Reset clears pending, enable, routing, control, all priorities and both request lines.
- R10: Word 0x40 is read-only and returns 4. Writes to words 0x40 to 0xBF change nothing, and any word without a register reads as zero.
- R11: The control word at word 0 keeps only bits 2, 3, 18, 20, 22 and 23 of a write, so writing 0xFFFFFFFF reads back 0x00D4000C. Bit 21 is an abort flag: when bit 20 is set in the written value, writing 1 to bit 21 clears the flag. The flag is never set inside the block.
- R12: Read data is registered and is valid on the cycle after the read strobe. Vector acknowledges, forced pending writes and bus register writes take effect at the strobe edge, and the request lines at that same edge reflect the updated state. A source edge in the same cycle as a forced pending write or an acknowledge takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 64 | Level interrupt sources, sampled every cycle |
| reg_addr | input | 10 | Register word address (byte offset divided by 4) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid on the cycle after `reg_rd` |
| fast_req_o | output | 1 | Fast request line |
| norm_req_o | output | 1 | Normal request line |

## Verification
The assertions assume that the read and write strobes are never high together. They also assume that the sources are synchronous to `clk`, so that a level seen at an edge is the one the pending logic acts on. The bench raises only one strobe per bus task and changes source levels only on the falling clock edge. Where a scenario needs a source edge in the same cycle as a forced pending write, it drives both at one falling edge without a read in that cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // register word offsets; software depends on these positions
   localparam int OFS_CTL       = 0;
   localparam int OFS_MASK      = 1;
   localparam int OFS_EN_SET    = 2;
   localparam int OFS_EN_CLR    = 3;
   localparam int OFS_EN_HI     = 4;
   localparam int OFS_EN_LO     = 5;
   localparam int OFS_FS_HI     = 6;
   localparam int OFS_FS_LO     = 7;
   localparam int OFS_PRIO_BASE = 8;
   localparam int OFS_NVEC      = 16;
   localparam int OFS_FVEC      = 17;
   localparam int OFS_RAW_HI    = 18;
   localparam int OFS_RAW_LO    = 19;
   localparam int OFS_FRC_HI    = 20;
   localparam int OFS_FRC_LO    = 21;
   localparam int OFS_NPND_HI   = 22;
   localparam int OFS_NPND_LO   = 23;
   localparam int OFS_FPND_HI   = 24;
   localparam int OFS_FPND_LO   = 25;
   localparam int OFS_VERSION   = 'h40;

   localparam logic [31:0] VERSION_VAL = 32'd4;
   localparam logic [31:0] NO_VECTOR   = 32'hFFFF_FFFF;

   // control word fields
   localparam int CTL_ABF_EN   = 20;
   localparam int CTL_ABF_FLAG = 21;
   localparam logic [31:0] CTL_KEEP = 32'h00D4_000C;
endpackage

// File: rtl/pic_norm_arb.sv
module pic_norm_arb #(
   parameter int N  = 64,
   parameter int PW = 4,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]    elig,
   input  logic [N*PW-1:0] prio_flat,
   output logic            hit,
   output logic [IW-1:0]   win_idx,
   output logic [PW-1:0]   win_prio
);
   if (N < 2)  begin : g_bad_n  $error("pic_norm_arb: N must be at least 2"); end
   if (PW < 1) begin : g_bad_pw $error("pic_norm_arb: PW must be positive"); end

   // ascending scan with >= lets the higher index take a tie
   always_comb begin
      hit      = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < N; i++) begin
         if (elig[i] && (!hit || prio_flat[i*PW +: PW] >= win_prio)) begin
            hit      = 1'b1;
            win_idx  = IW'(i);
            win_prio = prio_flat[i*PW +: PW];
         end
      end
   end

   always_comb begin
      if (hit) begin
         AST_WIN_ELIGIBLE: assert (elig[win_idx]); // R5
      end
   end
endmodule

// File: rtl/pic_low_pick.sv
module pic_low_pick #(
   parameter int N = 64,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  elig,
   output logic          hit,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n $error("pic_low_pick: N must be at least 2"); end

   // descending scan: the last match written is the lowest index
   always_comb begin
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (elig[i]) idx = IW'(i);
      end
      hit = |elig;
   end

   always_comb begin
      if (hit) begin
         AST_LOWEST_FIRST: assert (elig[idx] && ((elig & ((N'(1) << idx) - N'(1))) == '0)); // R6
      end
   end
endmodule

// File: rtl/pic_thresh.sv
module pic_thresh #(
   parameter int N  = 64,
   parameter int PW = 4,
   parameter int MW = 5
) (
   input  logic [N-1:0]    elig,
   input  logic [N*PW-1:0] prio_flat,
   input  logic [MW-1:0]   mask,
   output logic            req
);
   localparam int CW = (PW > MW) ? PW : MW;

   if (MW <= PW) begin : g_bad_mw $error("pic_thresh: MW must exceed PW"); end

   logic [N-1:0] above;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign above[i] = CW'(prio_flat[i*PW +: PW]) > CW'(mask);
   end

   // an all-ones threshold passes every eligible source through
   assign req = (&mask) ? (|elig) : (|(elig & above));
endmodule

// File: rtl/prio_vic.sv
module prio_vic
   import pic_pkg::*;
#(
   parameter int SRC_N  = 64,
   parameter int PRIO_W = 4,
   parameter int MASK_W = 5,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  irq_src_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              fast_req_o,
   output logic              norm_req_o
);
   localparam int IDX_W      = $clog2(SRC_N);
   localparam int PER_WORD   = DATA_W / PRIO_W;
   localparam int PRIO_WORDS = SRC_N / PER_WORD;
   localparam int HALF       = DATA_W;
   localparam int VEC_HALF   = DATA_W / 2;

   if (DATA_W != 32)                  begin : g_bad_dw $error("prio_vic: DATA_W must be 32"); end
   if (SRC_N != 2*DATA_W)             begin : g_bad_n  $error("prio_vic: SRC_N must fill two data words"); end
   if (PER_WORD*PRIO_W != DATA_W)     begin : g_bad_pw $error("prio_vic: PRIO_W must divide DATA_W"); end
   if (ADDR_W < 8)                    begin : g_bad_aw $error("prio_vic: ADDR_W too narrow for the map"); end

   // ---------------- state ----------------
   logic [DATA_W-1:0]                  ctl_q,  ctl_n;
   logic [MASK_W-1:0]                  mask_q, mask_n;
   logic [SRC_N-1:0]                   en_q,   en_n;
   logic [SRC_N-1:0]                   fsel_q, fsel_n;
   logic [SRC_N-1:0]                   pend_q, pend_n;
   logic [SRC_N-1:0]                   src_q;
   logic [PRIO_WORDS-1:0][DATA_W-1:0]  prio_q, prio_n;
   logic                               fast_n, norm_n;
   logic [DATA_W-1:0]                  rd_val;

   function automatic logic at(input int ofs);
      return reg_addr == ADDR_W'(ofs);
   endfunction

   // ---------------- source edges ----------------
   logic [SRC_N-1:0] rise, fall;
   assign rise = irq_src_i & ~src_q;
   assign fall = ~irq_src_i & src_q;

   // ---------------- current-state selection ----------------
   logic [SRC_N-1:0]  elig_norm, elig_fast;
   logic              norm_hit, fast_hit;
   logic [IDX_W-1:0]  norm_idx, fast_idx;
   logic [PRIO_W-1:0] norm_prio;

   assign elig_norm = pend_q & en_q & ~fsel_q;
   assign elig_fast = pend_q & en_q &  fsel_q;

   pic_norm_arb #(.N(SRC_N), .PW(PRIO_W)) u_norm_arb (
      .elig      (elig_norm),
      .prio_flat (prio_q),
      .hit       (norm_hit),
      .win_idx   (norm_idx),
      .win_prio  (norm_prio)
   );

   pic_low_pick #(.N(SRC_N)) u_fast_pick (
      .elig (elig_fast),
      .hit  (fast_hit),
      .idx  (fast_idx)
   );

   logic nack, fack;
   assign nack = reg_rd && at(OFS_NVEC) && norm_hit;
   assign fack = reg_rd && at(OFS_FVEC) && fast_hit;

   // ---------------- next state ----------------
   always_comb begin
      ctl_n  = ctl_q;
      mask_n = mask_q;
      en_n   = en_q;
      fsel_n = fsel_q;
      prio_n = prio_q;
      pend_n = pend_q;

      if (reg_wr) begin
         if (at(OFS_CTL)) begin
            ctl_n = reg_wdata & CTL_KEEP;
            ctl_n[CTL_ABF_FLAG] = ctl_q[CTL_ABF_FLAG]
                                & ~(ctl_n[CTL_ABF_EN] & reg_wdata[CTL_ABF_FLAG]);
         end
         if (at(OFS_MASK))   mask_n = reg_wdata[MASK_W-1:0];
         if (at(OFS_EN_SET)) en_n[reg_wdata[IDX_W-1:0]] = 1'b1;
         if (at(OFS_EN_CLR)) en_n[reg_wdata[IDX_W-1:0]] = 1'b0;
         if (at(OFS_EN_HI))  en_n[SRC_N-1:HALF]   = reg_wdata;
         if (at(OFS_EN_LO))  en_n[HALF-1:0]       = reg_wdata;
         if (at(OFS_FS_HI))  fsel_n[SRC_N-1:HALF] = reg_wdata;
         if (at(OFS_FS_LO))  fsel_n[HALF-1:0]     = reg_wdata;
         if (at(OFS_FRC_HI)) pend_n[SRC_N-1:HALF] = reg_wdata;
         if (at(OFS_FRC_LO)) pend_n[HALF-1:0]     = reg_wdata;
         for (int j = 0; j < PRIO_WORDS; j++) begin
            if (at(OFS_PRIO_BASE + PRIO_WORDS - 1 - j)) prio_n[j] = reg_wdata;
         end
      end

      if (nack) pend_n[norm_idx] = 1'b0;
      if (fack) pend_n[fast_idx] = 1'b0;

      // source edges are applied last so they win over bus effects
      pend_n = (pend_n | rise) & ~fall;
   end

   // request lines are registered from the updated state
   assign fast_n = |(pend_n & en_n & fsel_n);

   pic_thresh #(.N(SRC_N), .PW(PRIO_W), .MW(MASK_W)) u_thresh (
      .elig      (pend_n & en_n & ~fsel_n),
      .prio_flat (prio_n),
      .mask      (mask_n),
      .req       (norm_n)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rd_val = '0;
      case (reg_addr)
         ADDR_W'(OFS_CTL):     rd_val = ctl_q;
         ADDR_W'(OFS_MASK):    rd_val = DATA_W'(mask_q);
         ADDR_W'(OFS_EN_HI):   rd_val = en_q[SRC_N-1:HALF];
         ADDR_W'(OFS_EN_LO):   rd_val = en_q[HALF-1:0];
         ADDR_W'(OFS_FS_HI):   rd_val = fsel_q[SRC_N-1:HALF];
         ADDR_W'(OFS_FS_LO):   rd_val = fsel_q[HALF-1:0];
         ADDR_W'(OFS_NVEC):    rd_val = norm_hit ? {VEC_HALF'(norm_idx), VEC_HALF'(norm_prio)} : NO_VECTOR;
         ADDR_W'(OFS_FVEC):    rd_val = fast_hit ? DATA_W'(fast_idx) : NO_VECTOR;
         ADDR_W'(OFS_RAW_HI):  rd_val = pend_q[SRC_N-1:HALF];
         ADDR_W'(OFS_RAW_LO):  rd_val = pend_q[HALF-1:0];
         ADDR_W'(OFS_NPND_HI): rd_val = elig_norm[SRC_N-1:HALF];
         ADDR_W'(OFS_NPND_LO): rd_val = elig_norm[HALF-1:0];
         ADDR_W'(OFS_FPND_HI): rd_val = elig_fast[SRC_N-1:HALF];
         ADDR_W'(OFS_FPND_LO): rd_val = elig_fast[HALF-1:0];
         ADDR_W'(OFS_VERSION): rd_val = VERSION_VAL;
         default:              rd_val = '0;
      endcase
      for (int j = 0; j < PRIO_WORDS; j++) begin
         if (at(OFS_PRIO_BASE + PRIO_WORDS - 1 - j)) rd_val = prio_q[j];
      end
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         mask_q     <= '1;
         en_q       <= '0;
         fsel_q     <= '0;
         pend_q     <= '0;
         src_q      <= '0;
         prio_q     <= '0;
         fast_req_o <= 1'b0;
         norm_req_o <= 1'b0;
         reg_rdata  <= '0;
      end else begin
         ctl_q      <= ctl_n;
         mask_q     <= mask_n;
         en_q       <= en_n;
         fsel_q     <= fsel_n;
         pend_q     <= pend_n;
         src_q      <= irq_src_i;
         prio_q     <= prio_n;
         fast_req_o <= fast_n;
         norm_req_o <= norm_n;
         if (reg_rd) reg_rdata <= rd_val;
      end
   end

   // ---------------- assertions ----------------
   AST_FAST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      fast_req_o == |(pend_q & en_q & fsel_q)); // R2

   AST_NACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (nack && !rise[norm_idx]) |=> !pend_q[$past(norm_idx)]); // R5

   AST_FACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fack && !rise[fast_idx]) |=> !pend_q[$past(fast_idx)]); // R6

   AST_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && at(OFS_NVEC) && !norm_hit) |=> reg_rdata == NO_VECTOR); // R5

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && at(OFS_EN_SET)) |=> en_q[$past(reg_wdata[IDX_W-1:0])]); // R7

   AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R1
endmodule

// File: tb/prio_vic_bench.sv
`timescale 1ns/1ps
module prio_vic_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] src;
   logic [9:0]  addr;
   logic        wr, rd;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        fast_req, norm_req;

   int checks = 0;
   int errors = 0;
   logic [31:0] v;

   always #2.5 clk = ~clk;

   prio_vic u_prio_vic (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_src_i  (src),
      .reg_addr   (addr),
      .reg_wr     (wr),
      .reg_rd     (rd),
      .reg_wdata  (wdata),
      .reg_rdata  (rdata),
      .fast_req_o (fast_req),
      .norm_req_o (norm_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src = '0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      addr = 10'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      addr = 10'(a); rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic set_src(input int n, input logic lvl);
      src[n] = lvl;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9 fast line at reset", 32'(fast_req), 0);
      chk("R9 normal line at reset", 32'(norm_req), 0);
      bus_rd(1, v);  chk("R9 threshold reset", v, 32'h1F);
      bus_rd(0, v);  chk("R9 control reset", v, 0);
      bus_rd(5, v);  chk("R9 enable reset", v, 0);
      bus_rd(15, v); chk("R9 priority reset", v, 0);
      bus_rd('h40, v); chk("R10 version word", v, 4);
   endtask

   task automatic t_enable();
      do_reset();
      bus_wr(2, 32'd5);    bus_rd(5, v); chk("R7 set enable 5", v, 32'h20);
      bus_wr(2, 32'h68);   bus_rd(4, v); chk("R7 set enable uses low 6 bits", v, 32'h100);
      bus_rd(2, v);        chk("R7 set word reads zero", v, 0);
      bus_rd(3, v);        chk("R7 clear word reads zero", v, 0);
      bus_wr(3, 32'd5);    bus_rd(5, v); chk("R7 clear enable 5", v, 0);
      bus_wr(4, 32'hA5A5_A5A5); bus_rd(4, v); chk("R8 enable high half", v, 32'hA5A5_A5A5);
      bus_wr(7, 32'h1234);      bus_rd(7, v); chk("R8 routing low half", v, 32'h1234);
      bus_wr(6, 32'h8000_0001); bus_rd(6, v); chk("R8 routing high half", v, 32'h8000_0001);
   endtask

   task automatic t_fast();
      do_reset();
      bus_wr(7, 32'h20); bus_wr(6, 32'h100);
      bus_wr(5, 32'h20); bus_wr(4, 32'h100);
      chk("R2 fast idle", 32'(fast_req), 0);
      set_src(40, 1'b1); chk("R2 fast raised by source 40", 32'(fast_req), 1);
      set_src(5, 1'b1);  chk("R2 normal stays low", 32'(norm_req), 0);
      bus_rd(17, v);     chk("R6 fast vector lowest first", v, 5);
      bus_rd(19, v);     chk("R6 acknowledge clears pending 5", v, 0);
      chk("R2 fast held by source 40", 32'(fast_req), 1);
      bus_rd(17, v);     chk("R6 fast vector next", v, 40);
      chk("R12 fast line drops at acknowledge edge", 32'(fast_req), 0);
      bus_rd(17, v);     chk("R6 fast vector empty", v, 32'hFFFF_FFFF);
      bus_rd(18, v);     chk("R1 pending high cleared", v, 0);
      set_src(5, 1'b0); set_src(5, 1'b1);
      bus_rd(19, v);     chk("R1 new rising edge sets pending", v, 32'h20);
      set_src(5, 1'b0);
      bus_rd(19, v);     chk("R1 falling edge clears pending", v, 0);
   endtask

   task automatic t_thresh();
      do_reset();
      bus_wr(14, 32'h300); bus_wr(2, 32'd10);
      bus_rd(14, v); chk("R4 source 10 priority in word 14", v, 32'h300);
      bus_rd(15, v); chk("R4 word 15 untouched", v, 0);
      set_src(10, 1'b1); chk("R3 threshold 0x1F passes", 32'(norm_req), 1);
      bus_wr(1, 32'd3);  chk("R3 priority equal to threshold blocked", 32'(norm_req), 0);
      bus_wr(1, 32'd2);  chk("R3 priority above threshold", 32'(norm_req), 1);
      bus_wr(1, 32'h10); chk("R3 threshold above all priorities", 32'(norm_req), 0);
      bus_wr(1, 32'hFF);
      bus_rd(1, v);      chk("R9 threshold keeps 5 bits", v, 32'h1F);
      chk("R3 all-ones threshold again", 32'(norm_req), 1);
   endtask

   task automatic t_nvec();
      do_reset();
      bus_wr(15, 32'h900);        // source 2 priority 9
      bus_wr(14, 32'h0001_0300);  // source 10 prio 3, source 12 prio 1
      bus_wr(13, 32'h0003_0000);  // source 20 prio 3
      bus_wr(9,  32'h0000_0F00);  // source 50 prio 15
      bus_wr(6,  32'h0004_0000);  // source 50 fast-routed
      bus_wr(2, 2); bus_wr(2, 10); bus_wr(2, 12); bus_wr(2, 20); bus_wr(2, 50);
      src = (64'd1 << 2) | (64'd1 << 10) | (64'd1 << 12) | (64'd1 << 20) | (64'd1 << 50);
      @(negedge clk);
      chk("R3 normal line", 32'(norm_req), 1);
      bus_rd(23, v); chk("R8 masked normal low", v, 32'h0010_1404);
      bus_rd(24, v); chk("R8 masked fast high", v, 32'h0004_0000);
      bus_rd(16, v); chk("R5 highest priority wins", v, 32'h0002_0009);
      bus_rd(16, v); chk("R5 tie goes to higher index", v, 32'h0014_0003);
      bus_rd(16, v); chk("R5 remaining priority 3", v, 32'h000A_0003);
      bus_rd(16, v); chk("R5 lowest priority last", v, 32'h000C_0001);
      bus_rd(16, v); chk("R5 no eligible source", v, 32'hFFFF_FFFF);
      chk("R5 normal line drops", 32'(norm_req), 0);
      chk("R2 fast line unaffected", 32'(fast_req), 1);
   endtask

   task automatic t_force();
      do_reset();
      bus_wr(21, 32'hF0F0_0001); bus_rd(19, v); chk("R1 force low word", v, 32'hF0F0_0001);
      bus_wr(20, 32'h80);        bus_rd(18, v); chk("R1 force high word", v, 32'h80);
      bus_wr(18, 32'hFFFF_FFFF); bus_rd(18, v); chk("R8 raw pending read-only", v, 32'h80);
      bus_wr(22, 32'hFFFF_FFFF); bus_rd(18, v); chk("R8 masked view read-only", v, 32'h80);
      bus_wr(5, 32'h0000_FFFF); bus_wr(7, 32'h1);
      bus_rd(25, v); chk("R8 masked fast low", v, 32'h1);
      bus_rd(23, v); chk("R8 masked normal low", v, 0);
      chk("R2 forced fast source", 32'(fast_req), 1);
      // force write of zero and a source edge in the same cycle
      addr = 10'd21; wdata = '0; wr = 1'b1; src[3] = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      bus_rd(19, v); chk("R12 source edge wins over force", v, 32'h8);
      chk("R2 fast line follows forced clear", 32'(fast_req), 0);
   endtask

   task automatic t_ctl_misc();
      do_reset();
      bus_wr(0, 32'hFFFF_FFFF); bus_rd(0, v); chk("R11 control keeps defined bits", v, 32'h00D4_000C);
      bus_wr(0, 32'h0020_0000); bus_rd(0, v); chk("R11 abort flag not stored", v, 0);
      bus_wr('h40, 32'h0);      bus_rd('h40, v); chk("R10 version ignores writes", v, 4);
      bus_wr('hBF, 32'hFFFF_FFFF); bus_rd('hBF, v); chk("R10 ignored range reads zero", v, 0);
      bus_rd(1, v);    chk("R10 ignored write left threshold", v, 32'h1F);
      bus_rd('h20, v); chk("R10 unknown word reads zero", v, 0);
      bus_rd('hC0, v); chk("R10 unknown word beyond range", v, 0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_enable();
      t_fast();
      t_thresh();
      t_nvec();
      t_force();
      t_ctl_misc();
      summary();
      $finish;
   end
endmodule